// File: doc/BRIEF.md
# Card-Access Teller Machine Controller

This block is the control core of a simple teller machine. It runs on a slow 20 Hz system clock, so one cycle is 50 ms. A card is inserted, the holder proves a 4-bit PIN within three tries, and then works from a small menu. From the menu the holder can deposit or withdraw amounts taken from a 4-bit switch value, or change the PIN. The PIN and a 16-bit balance are held across logouts and are cleared only by the asynchronous reset.

Three buttons drive it: select, secondary and back. Each arrives as a clean one-cycle pulse. The block drives eight state LEDs and four active-low seven-segment codes. The segment codes show either a short text message or the balance as four hex digits. A shared retry counter shows the attempts left, both on the LEDs and as the last character of the message. Two timed lockouts ignore every button. The first follows three wrong PINs and lasts 100 cycles before returning to idle. The second follows an overdraft attempt and lasts 50 cycles before returning to the money screen.

Top module: `teller_ctrl`

## Requirements
- R1: After reset the block is idle, the PIN is 0000, the balance is 0, "CArd" is shown and led = 8'h01.
- R2: In idle, select moves to PIN entry, which shows "PE-3" with led = 8'h80. Secondary and back do nothing in idle.
- R3: In PIN entry, a select with a switch value other than the PIN counts as a wrong try. The first wrong try shows "PE-2" with led = 8'hC0. The second shows "PE-1" with led = 8'hE0.
- R4: A third wrong PIN in a row enters a lockout that shows "FAIL" with led = 8'hFF for exactly 100 cycles. Every button is ignored during the lockout. When it ends, the block returns to idle.
- R5: Back during PIN entry returns to idle. A select whose switch value equals the PIN enters the menu, which shows "OPEn" with led = 8'h10.
- R6: In the menu, select goes to money, secondary goes to PIN change and back goes to idle.
- R7: The money state lights led = 8'h08 and shows the balance as hex digits, left-most digit most significant. Select adds the switch value and saturates at 16'hFFFF. Secondary subtracts the switch value when it does not exceed the balance. Back returns to the menu.
- R8: A withdrawal larger than the balance leaves the balance unchanged. It shows "-NA-" with led = 8'hFF for exactly 50 cycles, ignoring all buttons, and then returns to money.
- R9: PIN change starts at "PC-3" with led = 8'h04. Wrong current PINs step to "PC-2" with 8'h06, then "PC-1" with 8'h07. A third wrong entry triggers the 100-cycle "FAIL" lockout and then idle.
- R10: A correct current PIN shows "PASS" with led = 8'h02. The next select stores the switch value as the PIN and returns to the menu. Back in either PIN-change step returns to the menu and leaves the PIN unchanged.
- R11: The try count is reloaded to three on every entry to PIN entry or PIN change.
- R12: When buttons pulse together, back wins over select and select wins over secondary.
- R13: The PIN and balance survive logout and re-login.
- R14: Segment codes are in abcdefg order (bit 6 = a) and active low, with segD3 the left-most display. The glyphs are:
  - 0/O = 0000001, 1/I = 1001111, 2 = 0010010, 3 = 0000110, 4 = 1001100
  - 5/S = 0100100, 6 = 0100000, 7 = 0001111, 8 = 0000000, 9 = 0000100
  - A = 0001000, b = 1100000, C = 0110001, d = 1000010, E = 0110000, F = 0111000
  - r = 1111010, P = 0011000, - = 1111110, L = 1110001, n = 1101010, N = 0001001

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 Hz system clock |
| rst | input | 1 | Asynchronous reset, active high |
| btnSel | input | 1 | Select pulse: card, enter PIN, deposit, menu choice |
| btnAlt | input | 1 | Secondary pulse: withdraw, PIN-change choice |
| btnBack | input | 1 | Back / logout pulse |
| sw | input | 4 | PIN or amount value |
| led | output | 8 | State indicator LEDs |
| segD3 | output | 7 | Left-most display, abcdefg active low |
| segD2 | output | 7 | Second display |
| segD1 | output | 7 | Third display |
| segD0 | output | 7 | Right-most display |

## Verification
Each of the sixteen switch values is submitted as a login PIN. Only the stored value may open the menu, and every other value must step the try counter; a back press then re-entry must show the count reloaded. Every deposit amount from 1 to 15 is applied and checked against an arithmetic balance model. The balance is then driven into saturation and walked down by repeated withdrawals, so that exact-zero withdrawals and overdraft attempts separate a correct comparison from an off-by-one. Button combinations tell the priority order apart, and both lockouts are probed one cycle before and at their expiry, with buttons pressed, to pin down their length.

// File: rtl/teller_pkg.sv
package teller_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PIN, ST_MENU, ST_MONEY, ST_CHK, ST_NEWPIN, ST_LOCKOUT, ST_NOFUNDS
  } stateT;

  // control -> datapath strobes
  typedef struct packed {
    logic ldPin;
    logic addBal;
    logic subBal;
    logic retryInit;
    logic retryDec;
    logic tmrRun;
  } strobeT;

  // character codes: 0..15 are hex digits, the rest are letters
  localparam logic [4:0] CH_R    = 5'd16;
  localparam logic [4:0] CH_P    = 5'd17;
  localparam logic [4:0] CH_DASH = 5'd18;
  localparam logic [4:0] CH_L    = 5'd19;
  localparam logic [4:0] CH_LN   = 5'd20;
  localparam logic [4:0] CH_UN   = 5'd21;

  // abcdefg, bit 6 = a, active low
  function automatic logic [6:0] glyph(input logic [4:0] code);
    case (code)
      5'd0:    glyph = 7'b0000001;
      5'd1:    glyph = 7'b1001111;
      5'd2:    glyph = 7'b0010010;
      5'd3:    glyph = 7'b0000110;
      5'd4:    glyph = 7'b1001100;
      5'd5:    glyph = 7'b0100100;
      5'd6:    glyph = 7'b0100000;
      5'd7:    glyph = 7'b0001111;
      5'd8:    glyph = 7'b0000000;
      5'd9:    glyph = 7'b0000100;
      5'd10:   glyph = 7'b0001000;
      5'd11:   glyph = 7'b1100000;
      5'd12:   glyph = 7'b0110001;
      5'd13:   glyph = 7'b1000010;
      5'd14:   glyph = 7'b0110000;
      5'd15:   glyph = 7'b0111000;
      CH_R:    glyph = 7'b1111010;
      CH_P:    glyph = 7'b0011000;
      CH_DASH: glyph = 7'b1111110;
      CH_L:    glyph = 7'b1110001;
      CH_LN:   glyph = 7'b1101010;
      CH_UN:   glyph = 7'b0001001;
      default: glyph = 7'b1111111;
    endcase
  endfunction

endpackage

// File: rtl/teller_data.sv
module teller_data
  import teller_pkg::*;
#(
  parameter int SW_W       = 4,
  parameter int BAL_W      = 16,
  parameter int TRIES      = 3,
  parameter int TRY_W      = $clog2(TRIES + 1),
  parameter int LOCK_LONG  = 100,
  parameter int LOCK_SHORT = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SW_W-1:0]   sw,
  input  strobeT            strobe,
  output logic              pinMatch,
  output logic              overdraw,
  output logic              lastTry,
  output logic              longDone,
  output logic              shortDone,
  output logic [TRY_W-1:0]  triesLeft,
  output logic [BAL_W-1:0]  balance
);

  localparam int TMR_W = $clog2(LOCK_LONG + 1);
  localparam logic [TMR_W-1:0] LONG_END  = TMR_W'(LOCK_LONG - 1);
  localparam logic [TMR_W-1:0] SHORT_END = TMR_W'(LOCK_SHORT - 1);

  logic [SW_W-1:0]  pinReg;
  logic [BAL_W:0]   sum;
  logic [TMR_W-1:0] tmr;

  always_comb begin
    sum       = {1'b0, balance} + (BAL_W+1)'(sw);
    pinMatch  = (sw == pinReg);
    overdraw  = (BAL_W'(sw) > balance);
    lastTry   = (triesLeft == TRY_W'(1));
    longDone  = (tmr == LONG_END);
    shortDone = (tmr == SHORT_END);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pinReg    <= '0;
      balance   <= '0;
      triesLeft <= TRY_W'(TRIES);
      tmr       <= '0;
    end else begin
      if (strobe.ldPin) pinReg <= sw;
      if (strobe.addBal)
        balance <= sum[BAL_W] ? '1 : sum[BAL_W-1:0];
      else if (strobe.subBal)
        balance <= balance - BAL_W'(sw);
      if (strobe.retryInit)     triesLeft <= TRY_W'(TRIES);
      else if (strobe.retryDec) triesLeft <= triesLeft - TRY_W'(1);
      tmr <= strobe.tmrRun ? tmr + TMR_W'(1) : '0;
    end
  end

  // R7: the control never subtracts more than the balance holds
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.subBal |-> !overdraw);

  // R7: a deposit never lowers the balance (saturation, no wrap)
  p_dep_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.addBal |=> balance >= $past(balance));

  // R8: balance only moves on a deposit or withdrawal strobe
  p_bal_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(strobe.addBal || strobe.subBal) |=> $stable(balance));

  // R10: PIN only changes on the store strobe
  p_pin_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !strobe.ldPin |=> $stable(pinReg));

  // R3: try count stays within 1..TRIES
  p_tries_range_r3: assert property (@(posedge clk) disable iff (rst)
    (triesLeft != '0) && (triesLeft <= TRY_W'(TRIES)));

endmodule

// File: rtl/teller_fsm.sv
module teller_fsm
  import teller_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   btnSel,
  input  logic   btnAlt,
  input  logic   btnBack,
  input  logic   pinMatch,
  input  logic   overdraw,
  input  logic   lastTry,
  input  logic   longDone,
  input  logic   shortDone,
  output stateT  state,
  output strobeT strobe
);

  stateT nextState;
  logic  goBack, goSel, goAlt;

  // R12: back > select > secondary
  always_comb begin
    goBack = btnBack;
    goSel  = btnSel & ~btnBack;
    goAlt  = btnAlt & ~btnBack & ~btnSel;
  end

  always_comb begin
    nextState     = state;
    strobe        = '0;
    strobe.tmrRun = (state == ST_LOCKOUT) || (state == ST_NOFUNDS);
    case (state)
      ST_IDLE:
        if (goSel) begin
          nextState        = ST_PIN;
          strobe.retryInit = 1'b1;
        end
      ST_PIN, ST_CHK:
        if (goBack) begin
          nextState = (state == ST_PIN) ? ST_IDLE : ST_MENU;
        end else if (goSel) begin
          if (pinMatch) begin
            nextState        = (state == ST_PIN) ? ST_MENU : ST_NEWPIN;
            strobe.retryInit = 1'b1;
          end else if (lastTry) begin
            nextState = ST_LOCKOUT;
          end else begin
            strobe.retryDec = 1'b1;
          end
        end
      ST_MENU:
        if (goBack)     nextState = ST_IDLE;
        else if (goSel) nextState = ST_MONEY;
        else if (goAlt) begin
          nextState        = ST_CHK;
          strobe.retryInit = 1'b1;
        end
      ST_MONEY:
        if (goBack)     nextState = ST_MENU;
        else if (goSel) strobe.addBal = 1'b1;
        else if (goAlt) begin
          if (overdraw) nextState = ST_NOFUNDS;
          else          strobe.subBal = 1'b1;
        end
      ST_NEWPIN:
        if (goBack) nextState = ST_MENU;
        else if (goSel) begin
          nextState    = ST_MENU;
          strobe.ldPin = 1'b1;
        end
      ST_LOCKOUT:
        if (longDone) nextState = ST_IDLE;
      ST_NOFUNDS:
        if (shortDone) nextState = ST_MONEY;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  p_fail_exit_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCKOUT && longDone) |=> state == ST_IDLE);

  p_fail_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCKOUT && !longDone) |=> state == ST_LOCKOUT);

  p_nsf_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NOFUNDS && shortDone) |=> state == ST_MONEY);

  p_back_pin_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PIN && btnBack) |=> state == ST_IDLE);

endmodule

// File: rtl/teller_disp.sv
module teller_disp
  import teller_pkg::*;
#(
  parameter int BAL_W = 16,
  parameter int TRY_W = 2
) (
  input  stateT             state,
  input  logic [TRY_W-1:0]  triesLeft,
  input  logic [BAL_W-1:0]  balance,
  output logic [7:0]        led,
  output logic [6:0]        segs [4]
);

  localparam int DIGITS = 4;

  logic [4:0] ch [DIGITS];   // ch[3] is left-most
  logic       le2, le1;

  always_comb begin
    le2 = (triesLeft <= TRY_W'(2));
    le1 = (triesLeft <= TRY_W'(1));
    led = 8'h00;
    for (int i = 0; i < DIGITS; i++) ch[i] = CH_DASH;
    case (state)
      ST_IDLE: begin
        led = 8'h01;
        ch[3] = 5'hC; ch[2] = 5'hA; ch[1] = CH_R; ch[0] = 5'hD;
      end
      ST_PIN: begin
        led = {1'b1, le2, le1, 5'b0};
        ch[3] = CH_P; ch[2] = 5'hE; ch[1] = CH_DASH; ch[0] = 5'(triesLeft);
      end
      ST_MENU: begin
        led = 8'h10;
        ch[3] = 5'h0; ch[2] = CH_P; ch[1] = 5'hE; ch[0] = CH_LN;
      end
      ST_MONEY: begin
        led = 8'h08;
        for (int i = 0; i < DIGITS; i++) ch[i] = {1'b0, balance[4*i +: 4]};
      end
      ST_CHK: begin
        led = {5'b0, 1'b1, le2, le1};
        ch[3] = CH_P; ch[2] = 5'hC; ch[1] = CH_DASH; ch[0] = 5'(triesLeft);
      end
      ST_NEWPIN: begin
        led = 8'h02;
        ch[3] = CH_P; ch[2] = 5'hA; ch[1] = 5'h5; ch[0] = 5'h5;
      end
      ST_LOCKOUT: begin
        led = 8'hFF;
        ch[3] = 5'hF; ch[2] = 5'hA; ch[1] = 5'h1; ch[0] = CH_L;
      end
      ST_NOFUNDS: begin
        led = 8'hFF;
        ch[3] = CH_DASH; ch[2] = CH_UN; ch[1] = 5'hA; ch[0] = CH_DASH;
      end
      default: led = 8'h00;
    endcase
  end

  for (genvar g = 0; g < DIGITS; g++) begin : g_seg
    assign segs[g] = glyph(ch[g]);
  end

endmodule

// File: rtl/teller_ctrl.sv
module teller_ctrl
  import teller_pkg::*;
#(
  parameter int SW_W       = 4,
  parameter int BAL_W      = 16,
  parameter int TRIES      = 3,
  parameter int LOCK_LONG  = 100,
  parameter int LOCK_SHORT = 50
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            btnSel,
  input  logic            btnAlt,
  input  logic            btnBack,
  input  logic [SW_W-1:0] sw,
  output logic [7:0]      led,
  output logic [6:0]      segD3,
  output logic [6:0]      segD2,
  output logic [6:0]      segD1,
  output logic [6:0]      segD0
);

  localparam int TRY_W = $clog2(TRIES + 1);

  stateT              state;
  strobeT             strobe;
  logic               pinMatch, overdraw, lastTry, longDone, shortDone;
  logic [TRY_W-1:0]   triesLeft;
  logic [BAL_W-1:0]   balance;
  logic [6:0]         segs [4];

  teller_fsm u_fsm (
    .clk(clk), .rst(rst), .btnSel(btnSel), .btnAlt(btnAlt), .btnBack(btnBack),
    .pinMatch(pinMatch), .overdraw(overdraw), .lastTry(lastTry),
    .longDone(longDone), .shortDone(shortDone), .state(state), .strobe(strobe)
  );

  teller_data #(
    .SW_W(SW_W), .BAL_W(BAL_W), .TRIES(TRIES), .TRY_W(TRY_W),
    .LOCK_LONG(LOCK_LONG), .LOCK_SHORT(LOCK_SHORT)
  ) u_data (
    .clk(clk), .rst(rst), .sw(sw), .strobe(strobe),
    .pinMatch(pinMatch), .overdraw(overdraw), .lastTry(lastTry),
    .longDone(longDone), .shortDone(shortDone),
    .triesLeft(triesLeft), .balance(balance)
  );

  teller_disp #(.BAL_W(BAL_W), .TRY_W(TRY_W)) u_disp (
    .state(state), .triesLeft(triesLeft), .balance(balance),
    .led(led), .segs(segs)
  );

  assign segD3 = segs[3];
  assign segD2 = segs[2];
  assign segD1 = segs[1];
  assign segD0 = segs[0];

endmodule

// File: tb/teller_ctrl_bench.sv
module teller_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       btnSel = 1'b0, btnAlt = 1'b0, btnBack = 1'b0;
  logic [3:0] sw = 4'h0;
  logic [7:0] led;
  logic [6:0] segD3, segD2, segD1, segD0;

  int checks = 0;
  int errors = 0;
  logic [15:0] mbal = 16'h0;
  logic [3:0]  mpin = 4'h0;

  teller_ctrl u_teller_ctrl (
    .clk(clk), .rst(rst), .btnSel(btnSel), .btnAlt(btnAlt), .btnBack(btnBack),
    .sw(sw), .led(led), .segD3(segD3), .segD2(segD2), .segD1(segD1), .segD0(segD0)
  );

  always #4 clk = ~clk;

  // R14 glyph table, written from the requirement
  function automatic logic [6:0] gl(input byte c);
    case (c)
      "0", "O": gl = 7'b0000001;
      "1", "I": gl = 7'b1001111;
      "2":      gl = 7'b0010010;
      "3":      gl = 7'b0000110;
      "4":      gl = 7'b1001100;
      "5", "S": gl = 7'b0100100;
      "6":      gl = 7'b0100000;
      "7":      gl = 7'b0001111;
      "8":      gl = 7'b0000000;
      "9":      gl = 7'b0000100;
      "A":      gl = 7'b0001000;
      "b":      gl = 7'b1100000;
      "C":      gl = 7'b0110001;
      "d":      gl = 7'b1000010;
      "E":      gl = 7'b0110000;
      "F":      gl = 7'b0111000;
      "r":      gl = 7'b1111010;
      "P":      gl = 7'b0011000;
      "-":      gl = 7'b1111110;
      "L":      gl = 7'b1110001;
      "n":      gl = 7'b1101010;
      "N":      gl = 7'b0001001;
      default:  gl = 7'b1111111;
    endcase
  endfunction

  function automatic byte hexCh(input logic [3:0] n);
    case (n)
      4'hA: hexCh = "A";
      4'hB: hexCh = "b";
      4'hC: hexCh = "C";
      4'hD: hexCh = "d";
      4'hE: hexCh = "E";
      4'hF: hexCh = "F";
      default: hexCh = byte'(8'd48 + {4'h0, n});
    endcase
  endfunction

  task automatic chkOut(input string tag, input byte c3, c2, c1, c0, input logic [7:0] el);
    logic [35:0] act, ex;
    act = {led, segD3, segD2, segD1, segD0};
    ex  = {el, gl(c3), gl(c2), gl(c1), gl(c0)};
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, ex);
    end
  endtask

  task automatic chkBal(input string tag);
    chkOut(tag, hexCh(mbal[15:12]), hexCh(mbal[11:8]), hexCh(mbal[7:4]),
           hexCh(mbal[3:0]), 8'h08);
  endtask

  // drive at a negedge, released at the next negedge (one posedge in between)
  task automatic press(input logic s, a, b, input logic [3:0] v);
    sw = v; btnSel = s; btnAlt = a; btnBack = b;
    @(negedge clk);
    btnSel = 1'b0; btnAlt = 1'b0; btnBack = 1'b0;
  endtask

  // entered a lockout in the last press; probe one cycle before and at expiry
  task automatic lockProbe(input string tag, input int n, input byte l3, l2, l1, l0);
    chkOut({tag, " entry"}, l3, l2, l1, l0, 8'hFF);
    repeat (n - 2) @(negedge clk);
    press(1'b1, 1'b1, 1'b1, 4'h0);
    chkOut({tag, " still held with buttons"}, l3, l2, l1, l0, 8'hFF);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chkOut("R1 reset idle", "C", "A", "r", "d", 8'h01);

    press(1'b0, 1'b1, 1'b0, 4'h0);
    press(1'b0, 1'b0, 1'b1, 4'h0);
    chkOut("R2 secondary/back ignored in idle", "C", "A", "r", "d", 8'h01);
    press(1'b1, 1'b0, 1'b0, 4'h0);
    chkOut("R2 card in", "P", "E", "-", "3", 8'h80);

    // R5 / R11: every PIN value tried once
    for (int v = 0; v < 16; v++) begin
      press(1'b1, 1'b0, 1'b0, 4'(v));
      if (4'(v) == mpin) chkOut("R5 correct pin -> menu", "O", "P", "E", "n", 8'h10);
      else               chkOut("R3 wrong pin first", "P", "E", "-", "2", 8'hC0);
      press(1'b0, 1'b0, 1'b1, 4'h0);
      chkOut("R5 back to idle", "C", "A", "r", "d", 8'h01);
      press(1'b1, 1'b0, 1'b0, 4'h0);
      chkOut("R11 retry reloaded", "P", "E", "-", "3", 8'h80);
    end

    press(1'b1, 1'b0, 1'b0, 4'h7);
    chkOut("R3 wrong 1", "P", "E", "-", "2", 8'hC0);
    press(1'b1, 1'b0, 1'b0, 4'h7);
    chkOut("R3 wrong 2", "P", "E", "-", "1", 8'hE0);
    press(1'b1, 1'b0, 1'b0, 4'h7);
    lockProbe("R4 login lockout", 100, "F", "A", "I", "L");
    chkOut("R4 lockout ends in idle", "C", "A", "r", "d", 8'h01);

    press(1'b1, 1'b0, 1'b0, 4'h0);
    press(1'b1, 1'b0, 1'b0, mpin);
    press(1'b1, 1'b0, 1'b0, 4'h0);
    chkBal("R6 menu select -> money");

    for (int v = 1; v < 16; v++) begin
      press(1'b1, 1'b0, 1'b0, 4'(v));
      mbal = mbal + 16'(v);
      chkBal("R7 deposit sweep");
    end
    press(1'b0, 1'b1, 1'b0, 4'h5);
    mbal = mbal - 16'h5;
    chkBal("R7 withdraw");

    while (mbal < 16'hFFF0) begin
      press(1'b1, 1'b0, 1'b0, 4'hF);
      mbal = mbal + 16'hF;
    end
    chkBal("R7 near top");
    press(1'b1, 1'b0, 1'b0, 4'hF);
    mbal = 16'hFFFF;
    chkBal("R7 saturate");
    press(1'b1, 1'b0, 1'b0, 4'h1);
    chkBal("R7 stays saturated");

    while (mbal >= 16'hF) begin
      press(1'b0, 1'b1, 1'b0, 4'hF);
      mbal = mbal - 16'hF;
    end
    chkBal("R7 walked down");
    press(1'b0, 1'b1, 1'b0, mbal[3:0]);
    mbal = 16'h0;
    chkBal("R7 withdraw to exactly zero");
    press(1'b1, 1'b0, 1'b0, 4'h3);
    mbal = 16'h3;
    press(1'b0, 1'b1, 1'b0, 4'h4);
    lockProbe("R8 overdraft lockout", 50, "-", "N", "A", "-");
    chkBal("R8 back in money, balance kept");
    press(1'b0, 1'b1, 1'b0, 4'h3);
    mbal = 16'h0;
    chkBal("R8 equal withdrawal allowed");

    press(1'b1, 1'b1, 1'b0, 4'h2);
    mbal = 16'h2;
    chkBal("R12 select beats secondary");
    press(1'b1, 1'b1, 1'b1, 4'h2);
    chkOut("R12 back beats select", "O", "P", "E", "n", 8'h10);
    press(1'b1, 1'b1, 1'b0, 4'h0);
    chkBal("R12 menu select beats secondary");
    press(1'b0, 1'b0, 1'b1, 4'h0);
    chkOut("R7 back to menu", "O", "P", "E", "n", 8'h10);

    press(1'b0, 1'b1, 1'b0, 4'h0);
    chkOut("R9 pin change start", "P", "C", "-", "3", 8'h04);
    press(1'b1, 1'b0, 1'b0, 4'h5);
    chkOut("R9 wrong current 1", "P", "C", "-", "2", 8'h06);
    press(1'b0, 1'b0, 1'b1, 4'h0);
    chkOut("R10 back to menu", "O", "P", "E", "n", 8'h10);
    press(1'b0, 1'b1, 1'b0, 4'h0);
    chkOut("R11 change retry reloaded", "P", "C", "-", "3", 8'h04);
    press(1'b1, 1'b0, 1'b0, mpin);
    chkOut("R10 pass", "P", "A", "S", "S", 8'h02);
    press(1'b0, 1'b0, 1'b1, 4'h9);
    chkOut("R10 back from pass", "O", "P", "E", "n", 8'h10);
    press(1'b0, 1'b1, 1'b0, 4'h0);
    press(1'b1, 1'b0, 1'b0, mpin);
    chkOut("R10 pin unchanged after back", "P", "A", "S", "S", 8'h02);
    press(1'b1, 1'b0, 1'b0, 4'h9);
    mpin = 4'h9;
    chkOut("R10 new pin stored", "O", "P", "E", "n", 8'h10);

    press(1'b0, 1'b0, 1'b1, 4'h0);
    chkOut("R6 menu back -> idle", "C", "A", "r", "d", 8'h01);
    press(1'b1, 1'b0, 1'b0, 4'h0);
    press(1'b1, 1'b0, 1'b0, 4'h0);
    chkOut("R13 old pin rejected", "P", "E", "-", "2", 8'hC0);
    press(1'b1, 1'b0, 1'b0, mpin);
    chkOut("R13 new pin accepted", "O", "P", "E", "n", 8'h10);
    press(1'b1, 1'b0, 1'b0, 4'h0);
    chkBal("R13 balance kept over logout");
    press(1'b0, 1'b0, 1'b1, 4'h0);
    press(1'b0, 1'b1, 1'b0, 4'h0);
    press(1'b1, 1'b0, 1'b0, 4'h1);
    press(1'b1, 1'b0, 1'b0, 4'h1);
    chkOut("R9 wrong current 2", "P", "C", "-", "1", 8'h07);
    press(1'b1, 1'b0, 1'b0, 4'h1);
    lockProbe("R9 change lockout", 100, "F", "A", "I", "L");
    chkOut("R9 lockout ends in idle", "C", "A", "r", "d", 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule